// File: doc/BRIEF.md
# Pulse-Per-Second Frequency Error Sampler

This block measures how far a local 5 MHz or 10 MHz reference oscillator drifts from its nominal rate, once per second, as the measuring front end of a satellite-disciplined oscillator. A narrow tick counter runs freely on the reference clock and is never cleared or preloaded. An asynchronous one-second timing pulse is brought into the reference clock domain and turned into a strobe one clock wide. That strobe takes a snapshot of the counter.

Each snapshot is subtracted from the previous one in modular arithmetic at the counter width, which gives the elapsed tick count regardless of where the counter started. The nominal count, reduced to the same width, is then subtracted. The result is presented as a small signed error. A sticky flag tells a polling host that a fresh error is waiting. The host acknowledges after reading, and an overrun bit records a result that was replaced before it was read. Because the expected error is only a few ticks, a five-bit counter is enough.

Top module: `pps_tick_sampler`

## Requirements
- R1: The tick counter advances by one on every reference clock edge, including during reset. Any two consecutive snapshots on `sample_o` differ by the number of clock cycles between the two pulse edges, modulo 2^CNT_W.
- R2: A rising edge of `pps_in` that is set up before clock edge k produces updated `err_o`/`new_o` after clock edge k+3. The outputs do not change after edge k+2.
- R3: Each rising edge of `pps_in` causes exactly one snapshot, however long the pulse stays high.
- R4: `err_o` equals (elapsed ticks − NOMINAL) mod 2^CNT_W, read as a CNT_W-bit two's-complement number and sign-extended to ERR_W bits. For example, an all-ones difference reads as −1, and a difference of 2^(CNT_W−1) reads as −2^(CNT_W−1).
- R5: The first snapshot after reset only primes the previous-snapshot register. `new_o` stays low and `err_o` keeps its reset value.
- R6: `new_o` rises with every snapshot after the first. A one-cycle pulse on `ack_in` clears it.
- R7: When a snapshot and `ack_in` fall in the same cycle, `new_o` is left set.
- R8: `overrun_o` is set when a snapshot arrives while `new_o` is high and `ack_in` is low. It is cleared by `ack_in`.
- R9: Synchronous active-high `rst` clears `new_o`, `overrun_o`, `err_o`, the synchronizer and the previous-snapshot register.
- R10: `ack_in` while `new_o` is low changes none of the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference oscillator clock |
| rst | input | 1 | Synchronous active-high reset (does not touch the tick counter) |
| pps_in | input | 1 | Asynchronous one-second timing pulse |
| ack_in | input | 1 | Host acknowledge after reading the error |
| sample_o | output | CNT_W | Raw counter value at the latest snapshot |
| err_o | output | ERR_W | Signed tick error of the last completed second |
| new_o | output | 1 | Sticky flag: an unread error is waiting |
| overrun_o | output | 1 | An unread error was replaced |

## Verification
If the previous-snapshot register or the priming bit is corrupted, the very next pulse shows it: `err_o` goes off by a constant, or `new_o` rises one pulse too early or too late. A wrong synchronizer or strobe stage shows up as a shifted update cycle, or as a second snapshot inside a long pulse. The second case sets `overrun_o` within one pulse period. A flag with the wrong priority shows up in the same cycle as the acknowledge that collides with it.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int unsigned DEF_CNT_W   = 5;
  localparam int unsigned DEF_ERR_W   = 8;
  localparam int unsigned DEF_NOMINAL = 5_000_000;
  localparam int unsigned DEF_SYNC    = 2;
endpackage

// File: rtl/pps_edge_strobe.sv
module pps_edge_strobe #(
  parameter int unsigned SYNC_STAGES = pps_pkg::DEF_SYNC
) (
  input  logic clk,
  input  logic rst,
  input  logic pps_i,
  output logic strobe_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   dly_q;
  logic                   strobe_q;

  // metastability chain
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pps_i};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pps_i;
      end
    end
  endgenerate

  // edge detector: one delay flop plus a registered strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      dly_q    <= sync_q[LAST];
      strobe_q <= sync_q[LAST] & ~dly_q;
    end
  end

  assign strobe_o = strobe_q;

  // R3: strobe never lasts two cycles
  p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    strobe_q |=> !strobe_q);

  // R2: a strobe is always preceded by a synchronized high level
  p_strobe_follows_sync_r2: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> $past(sync_q[LAST]));
endmodule

// File: rtl/tick_free_counter.sv
module tick_free_counter #(
  parameter int unsigned CNT_W = pps_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // deliberately no reset: power-up value is irrelevant to the result
  always_ff @(posedge clk) begin
    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R1: keeps stepping by one; rst only masks the check at start-up
  p_free_run_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q == CNT_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/pps_sample_diff.sv
module pps_sample_diff #(
  parameter int unsigned CNT_W   = pps_pkg::DEF_CNT_W,
  parameter int unsigned ERR_W   = pps_pkg::DEF_ERR_W,
  parameter int unsigned NOMINAL = pps_pkg::DEF_NOMINAL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] sample_o,
  output logic [ERR_W-1:0] err_o,
  output logic             new_o,
  output logic             ovr_o
);
  localparam logic [CNT_W-1:0] NOM_RES = CNT_W'(NOMINAL % (2 ** CNT_W));

  logic [CNT_W-1:0] sample_q;
  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] delta;
  logic [CNT_W-1:0] err_raw;
  logic [ERR_W-1:0] err_ext;
  logic [ERR_W-1:0] err_q;
  logic             primed_q;
  logic             new_q;
  logic             ovr_q;

  assign delta   = cnt_i - prev_q;
  assign err_raw = delta - NOM_RES;

  generate
    if (ERR_W > CNT_W) begin : g_sext
      assign err_ext = {{(ERR_W-CNT_W){err_raw[CNT_W-1]}}, err_raw};
    end else begin : g_trunc
      assign err_ext = err_raw[ERR_W-1:0];
    end
  endgenerate

  // raw snapshot: data only, no reset needed
  always_ff @(posedge clk) begin
    if (cap_i) sample_q <= cnt_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      err_q    <= '0;
      new_q    <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      if (cap_i) begin
        prev_q   <= cnt_i;
        primed_q <= 1'b1;
        if (primed_q) err_q <= err_ext;
      end
      // set has priority over acknowledge
      if (cap_i && primed_q)  new_q <= 1'b1;
      else if (ack_i)         new_q <= 1'b0;
      if (cap_i && primed_q && new_q && !ack_i) ovr_q <= 1'b1;
      else if (ack_i)                           ovr_q <= 1'b0;
    end
  end

  assign sample_o = sample_q;
  assign err_o    = err_q;
  assign new_o    = new_q;
  assign ovr_o    = ovr_q;

  // R6: a primed snapshot always raises the flag
  p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
    (cap_i && primed_q) |=> new_q);
  // R6: acknowledge without a snapshot clears the flag
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !cap_i) |=> !new_q);
  // R7: collision keeps the flag
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (cap_i && primed_q && ack_i) |=> new_q);
  // R8: unread result replaced
  p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    (cap_i && new_q && !ack_i) |=> ovr_q);
  // R5: the priming snapshot raises nothing
  p_prime_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (cap_i && !primed_q) |=> (!new_q && $stable(err_q)));
  // R4: error only moves on a snapshot
  p_err_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !cap_i |=> $stable(err_q));
  // R8: overrun never stands without a pending result
  p_ovr_implies_new_r8: assert property (@(posedge clk) disable iff (rst)
    ovr_q |-> new_q);
endmodule

// File: rtl/pps_tick_sampler.sv
module pps_tick_sampler #(
  parameter int unsigned CNT_W       = pps_pkg::DEF_CNT_W,
  parameter int unsigned ERR_W       = pps_pkg::DEF_ERR_W,
  parameter int unsigned NOMINAL     = pps_pkg::DEF_NOMINAL,
  parameter int unsigned SYNC_STAGES = pps_pkg::DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pps_in,
  input  logic             ack_in,
  output logic [CNT_W-1:0] sample_o,
  output logic [ERR_W-1:0] err_o,
  output logic             new_o,
  output logic             overrun_o
);
  logic             strobe;
  logic [CNT_W-1:0] ticks;

  pps_edge_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
    .clk      (clk),
    .rst      (rst),
    .pps_i    (pps_in),
    .strobe_o (strobe)
  );

  tick_free_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .cnt_o (ticks)
  );

  pps_sample_diff #(
    .CNT_W   (CNT_W),
    .ERR_W   (ERR_W),
    .NOMINAL (NOMINAL)
  ) u_diff (
    .clk      (clk),
    .rst      (rst),
    .cap_i    (strobe),
    .ack_i    (ack_in),
    .cnt_i    (ticks),
    .sample_o (sample_o),
    .err_o    (err_o),
    .new_o    (new_o),
    .ovr_o    (overrun_o)
  );
endmodule

// File: tb/pps_tick_sampler_test.sv
module pps_tick_sampler_test;
  localparam int W   = 5;
  localparam int EW  = 8;
  localparam int NOM = 100;
  localparam int MOD = 1 << W;
  localparam int NV  = 10;
  localparam int VP[NV] = '{100, 101, 99, 110, 90, 115, 116, 84, 117, 132};
  localparam int VE[NV] = '{0, 1, -1, 10, -10, 15, -16, -16, -15, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pps = 1'b0;
  logic ack = 1'b0;
  logic [W-1:0]  sample_o;
  logic [EW-1:0] err_o;
  logic new_o, overrun_o;

  int checks = 0;
  int errors = 0;
  int s_prev;

  always #2 clk = ~clk;

  pps_tick_sampler #(.CNT_W(W), .ERR_W(EW), .NOMINAL(NOM)) uut (
    .clk(clk), .rst(rst), .pps_in(pps), .ack_in(ack),
    .sample_o(sample_o), .err_o(err_o), .new_o(new_o), .overrun_o(overrun_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int errv();
    return int'($signed(err_o));
  endfunction

  // rising edge; returns after the cycle the outputs reflect it
  task automatic edge_in();
    pps = 1'b1;
    repeat (3) @(negedge clk);
    pps = 1'b0;
    @(negedge clk);
  endtask

  // acknowledge, then idle so that the next edge is p cycles after the last
  task automatic tail(int p);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R6 flag cleared by ack", int'(new_o), 0);
    chk("R8 overrun cleared by ack", int'(overrun_o), 0);
    repeat (p - 5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s1;
    repeat (4) @(negedge clk);
    chk("R9 reset new_o", int'(new_o), 0);
    chk("R9 reset overrun_o", int'(overrun_o), 0);
    chk("R9 reset err_o", errv(), 0);
    rst = 1'b0;
    @(negedge clk);

    // priming snapshot
    edge_in();
    chk("R5 prime leaves new_o low", int'(new_o), 0);
    chk("R5 prime leaves err_o", errv(), 0);
    s_prev = int'(sample_o);
    tail(VP[0]);   // ack with clear flag
    chk("R10 stray ack keeps err_o", errv(), 0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      edge_in();
      chk("R4 error value", errv(), VE[i]);
      chk("R6 flag set", int'(new_o), 1);
      chk("R1 snapshot spacing", (((int'(sample_o) - s_prev) % MOD) + MOD) % MOD, VP[i] % MOD);
      s_prev = int'(sample_o);
      tail((i + 1 < NV) ? VP[i + 1] : 50);
    end

    // R2 latency: 50-100 = -50 -> 14
    pps = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 no update after edge k+2", int'(new_o), 0);
    pps = 1'b0;
    @(negedge clk);
    chk("R2 update after edge k+3", int'(new_o), 1);
    chk("R4 wrap of -50", errv(), 14);
    repeat (36) @(negedge clk);

    // R8 overrun: second result without ack; 40-100 -> 4
    edge_in();
    chk("R8 overrun set", int'(overrun_o), 1);
    chk("R8 flag still set", int'(new_o), 1);
    chk("R4 error at period 40", errv(), 4);
    tail(40);

    // R7 collision: pending result, ack lands on the snapshot cycle
    edge_in();
    chk("R6 flag set before collision", int'(new_o), 1);
    repeat (36) @(negedge clk);
    pps = 1'b1;
    repeat (3) @(negedge clk);
    pps = 1'b0;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R7 set wins over ack", int'(new_o), 1);
    chk("R8 no overrun with concurrent ack", int'(overrun_o), 0);
    tail(40);

    // R3 long pulse: only one snapshot
    pps = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 capture in long pulse", int'(new_o), 1);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    repeat (20) @(negedge clk);
    chk("R3 no second capture", int'(new_o), 0);
    chk("R3 no overrun", int'(overrun_o), 0);
    pps = 1'b0;
    repeat (15) @(negedge clk);

    // R1 across reset: counter keeps running, reset re-primes
    edge_in();
    chk("R4 error after long pulse", errv(), 4);
    s1 = int'(sample_o);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 reset clears err_o", errv(), 0);
    chk("R9 reset clears new_o", int'(new_o), 0);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    edge_in();
    chk("R1 counter runs through reset", int'(sample_o), (s1 + 60) % MOD);
    chk("R5 re-prime after reset", int'(new_o), 0);
    repeat (96) @(negedge clk);
    edge_in();
    chk("R4 error after re-prime", errv(), 0);
    chk("R6 flag after re-prime", int'(new_o), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule